// File: doc/BRIEF.md
# DMA Block-Cipher Job Sequencer

This unit runs one cipher job at a time over a buffer in memory. Software writes three registers: a control word, a source address and a destination address. A start request then sends the unit through a fixed loop for each 16-byte block:

1. Read the block from the source address through a request/acknowledge memory port.
2. Pass the block to an external cipher datapath over a valid/ready pair, then collect the result over a second pair.
3. Write the result to the destination address.

After each block is written, both address registers step forward by 16. Software can read them back at any time. When the cipher-enable field is clear, step 2 is skipped and the unit works as a plain memory copier. The source and destination may be the same buffer, which gives in-place processing.

The start bit of the control word has three uses. Writing 1 launches a job. Writing 0 resets the engine and aborts any running job. Reading it returns the busy state. When a job ends and its interrupt-enable field is set, the unit raises an interrupt. The interrupt stays high until software next writes the control word. A memory response that reports an error stops the job early and sets a sticky error flag.

Top module: `blkcipher_dma_ctl`

## Requirements
- R1: After reset, all request and valid outputs, `coutReady` and `irq` are low, and all three registers read as zero.
- R2: The control word reads back as follows: bit 31 = busy, bit 30 = interrupt enable, bit 29 = error flag, bit 28 = cipher enable, bit 27 = decrypt (1) or encrypt (0), bit 12 = IV chaining, bits 11:0 = block count minus one. All other bits read zero, and software writes to bit 29 have no effect.
- R3: Writing the control word with bit 31 set while idle starts a job. Bit 31 then reads 1 until the job ends.
- R4: A job covers count+1 blocks. Block k is read from source+16k and written to destination+16k. Equal source and destination addresses are allowed.
- R5: With cipher enable set, each block goes out on `cinData` and its `cinData` value is held until `cinReady`. The value on `coutData` is what gets written. `cipherDecrypt` and `cipherChain` follow bits 27 and 12, and `cipherFirst` is high only for the first block of the job.
- R6: With cipher enable clear, `cinValid` stays low and each written block equals the block read.
- R7: Bits 3:0 of both address registers read zero whatever is written to them. Each block that completes adds 16 to both registers.
- R8: Bits 31:4 of a write to the source or destination register are stored while the unit is idle. The same write while busy is ignored.
- R9: When a job ends with interrupt enable set, `irq` goes high and stays high until the next control-word write. With interrupt enable clear, `irq` stays low.
- R10: A control-word write with bit 31 set while busy is ignored. The job and the stored fields do not change.
- R11: A control-word write with bit 31 clear aborts a running job. Busy and all requests drop on the next cycle, and the addresses keep their current values.
- R12: An acknowledge that carries the error flag, on a read or a write, ends the job at once. The error flag is set and the failing block does not advance the addresses. The next start clears the flag.
- R13: Only one of `memRdReq`, `memWrReq`, `cinValid` and `coutReady` is high at a time. A memory request is held until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset (0x0 control, 0x4 source, 0x8 destination) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| memRdReq | output | 1 | Block read request |
| memRdAddr | output | 32 | Block read address |
| memRdAck | input | 1 | Read acknowledge, one cycle |
| memRdErr | input | 1 | Read error, valid with acknowledge |
| memRdData | input | 128 | Read block, valid with acknowledge |
| memWrReq | output | 1 | Block write request |
| memWrAddr | output | 32 | Block write address |
| memWrData | output | 128 | Block to write |
| memWrAck | input | 1 | Write acknowledge, one cycle |
| memWrErr | input | 1 | Write error, valid with acknowledge |
| cinValid | output | 1 | Block offered to cipher |
| cinReady | input | 1 | Cipher accepts block |
| cinData | output | 128 | Block to cipher |
| cipherDecrypt | output | 1 | Cipher direction, 1 = decrypt |
| cipherChain | output | 1 | Chain from previous job instead of fresh IV |
| cipherFirst | output | 1 | Current block is the first of the job |
| coutValid | input | 1 | Cipher result valid |
| coutReady | output | 1 | Unit accepts result |
| coutData | input | 128 | Cipher result |
| irq | output | 1 | Job-complete interrupt |

## Verification
The bench checks the block-count field at its edges. A count of zero must move exactly one block, and an off-by-one sequencer would write a second block or end the job with none written. It starts a job and, while the job is held on a stalled read, writes a new start and a new source address. A design that honoured either write would change the stored fields or the block total. It aborts a job during a stalled read and checks that no write follows. It injects a read error on the second block and expects exactly one write, addresses advanced once, and the error flag set. Randomised jobs mix bypass and cipher modes, and in-place runs are included, so that wrong data routing or a missing address step shows up as a mismatched write log.

// File: rtl/bcdma_pkg.sv
`timescale 1ns/1ps
package bcdma_pkg;
  // control word bit positions (software-visible)
  localparam int unsigned BitStart = 31;
  localparam int unsigned BitIrqEn = 30;
  localparam int unsigned BitErr   = 29;
  localparam int unsigned BitCiph  = 28;
  localparam int unsigned BitDec   = 27;
  localparam int unsigned BitChain = 12;

  localparam logic [3:0] OfsCtrl = 4'h0;
  localparam logic [3:0] OfsSrc  = 4'h4;
  localparam logic [3:0] OfsDst  = 4'h8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CIN,
    ST_COUT,
    ST_WRITE
  } seqState_t;

  typedef struct packed {
    logic startJob;
    logic abortJob;
    logic capRead;
    logic capCipher;
    logic blockDone;
    logic jobEnd;
    logic setErr;
  } seqStrobe_t;
endpackage

// File: rtl/bcdma_ctrl.sv
`timescale 1ns/1ps
module bcdma_ctrl
  import bcdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStartReq,
  input  logic       wrAbortReq,
  input  logic       cipherEn,
  input  logic       lastBlock,
  input  logic       memRdAck,
  input  logic       memRdErr,
  input  logic       memWrAck,
  input  logic       memWrErr,
  input  logic       cinReady,
  input  logic       coutValid,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       memRdReq,
  output logic       memWrReq,
  output logic       cinValid,
  output logic       coutReady
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    stb       = '0;
    nextState = state;
    memRdReq  = 1'b0;
    memWrReq  = 1'b0;
    cinValid  = 1'b0;
    coutReady = 1'b0;
    case (state)
      ST_IDLE: begin
        if (wrStartReq) begin
          stb.startJob = 1'b1;
          nextState    = ST_READ;
        end
      end
      ST_READ: begin
        memRdReq = 1'b1;
        if (memRdAck) begin
          if (memRdErr) begin
            stb.setErr = 1'b1;
            stb.jobEnd = 1'b1;
            nextState  = ST_IDLE;
          end else begin
            stb.capRead = 1'b1;
            nextState   = cipherEn ? ST_CIN : ST_WRITE;
          end
        end
      end
      ST_CIN: begin
        cinValid = 1'b1;
        if (cinReady) nextState = ST_COUT;
      end
      ST_COUT: begin
        coutReady = 1'b1;
        if (coutValid) begin
          stb.capCipher = 1'b1;
          nextState     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memWrReq = 1'b1;
        if (memWrAck) begin
          if (memWrErr) begin
            stb.setErr = 1'b1;
            stb.jobEnd = 1'b1;
            nextState  = ST_IDLE;
          end else begin
            stb.blockDone = 1'b1;
            if (lastBlock) begin
              stb.jobEnd = 1'b1;
              nextState  = ST_IDLE;
            end else begin
              nextState = ST_READ;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
    // software reset of the engine overrides any step in progress
    if (wrAbortReq && state != ST_IDLE) begin
      stb          = '0;
      stb.abortJob = 1'b1;
      nextState    = ST_IDLE;
    end
  end
endmodule

// File: rtl/bcdma_dpath.sv
`timescale 1ns/1ps
module bcdma_dpath
  import bcdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  seqStrobe_t        stb,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] coutData,
  output logic              wrStartReq,
  output logic              wrAbortReq,
  output logic              cipherEn,
  output logic              decrypt,
  output logic              chainIv,
  output logic              firstBlock,
  output logic              lastBlock,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] blockBuf,
  output logic              irq
);
  localparam int unsigned BlkBytes = DATA_W / 8;
  localparam int unsigned AddrLsb  = $clog2(BlkBytes);
  localparam int unsigned HiW      = ADDR_W - AddrLsb;

  logic [HiW-1:0]   srcHi, dstHi;
  logic [CNT_W-1:0] blkCntM1, remain;
  logic             irqEn, errFlag, irqPend;

  logic ctrlSel, fieldLoad, srcWr, dstWr;
  assign ctrlSel    = regWrEn && (regAddr == OfsCtrl);
  assign wrStartReq = ctrlSel && regWrData[BitStart];
  assign wrAbortReq = ctrlSel && !regWrData[BitStart];
  assign fieldLoad  = ctrlSel && !(busy && regWrData[BitStart]);
  assign srcWr      = regWrEn && (regAddr == OfsSrc) && !busy;
  assign dstWr      = regWrEn && (regAddr == OfsDst) && !busy;

  // control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      cipherEn <= 1'b0;
      decrypt  <= 1'b0;
      chainIv  <= 1'b0;
      blkCntM1 <= '0;
    end else if (fieldLoad) begin
      irqEn    <= regWrData[BitIrqEn];
      cipherEn <= regWrData[BitCiph];
      decrypt  <= regWrData[BitDec];
      chainIv  <= regWrData[BitChain];
      blkCntM1 <= regWrData[CNT_W-1:0];
    end
  end

  // live address registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcHi <= '0;
      dstHi <= '0;
    end else begin
      if (srcWr)              srcHi <= regWrData[ADDR_W-1:AddrLsb];
      else if (stb.blockDone) srcHi <= srcHi + 1'b1;
      if (dstWr)              dstHi <= regWrData[ADDR_W-1:AddrLsb];
      else if (stb.blockDone) dstHi <= dstHi + 1'b1;
    end
  end

  assign srcAddr = {srcHi, {AddrLsb{1'b0}}};
  assign dstAddr = {dstHi, {AddrLsb{1'b0}}};

  // block counting within a job
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain     <= '0;
      firstBlock <= 1'b0;
    end else if (stb.startJob) begin
      remain     <= regWrData[CNT_W-1:0];
      firstBlock <= 1'b1;
    end else if (stb.abortJob) begin
      remain     <= '0;
      firstBlock <= 1'b0;
    end else if (stb.blockDone) begin
      if (remain != '0) remain <= remain - 1'b1;
      firstBlock <= 1'b0;
    end
  end

  assign lastBlock = (remain == '0);

  // single block buffer shared by read and cipher results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              blockBuf <= '0;
    else if (stb.capRead)   blockBuf <= memRdData;
    else if (stb.capCipher) blockBuf <= coutData;
  end

  // error flag and interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      if (stb.startJob)    errFlag <= 1'b0;
      else if (stb.setErr) errFlag <= 1'b1;
      if (stb.jobEnd && irqEn) irqPend <= 1'b1;
      else if (ctrlSel)        irqPend <= 1'b0;
    end
  end

  assign irq = irqPend;

  // register read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      OfsCtrl: begin
        regRdData[BitStart]    = busy;
        regRdData[BitIrqEn]    = irqEn;
        regRdData[BitErr]      = errFlag;
        regRdData[BitCiph]     = cipherEn;
        regRdData[BitDec]      = decrypt;
        regRdData[BitChain]    = chainIv;
        regRdData[CNT_W-1:0]   = blkCntM1;
      end
      OfsSrc:  regRdData[ADDR_W-1:0] = srcAddr;
      OfsDst:  regRdData[ADDR_W-1:0] = dstAddr;
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/blkcipher_dma_ctl.sv
`timescale 1ns/1ps
module blkcipher_dma_ctl
  import bcdma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdAck,
  input  logic              memRdErr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrReq,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrAck,
  input  logic              memWrErr,
  output logic              cinValid,
  input  logic              cinReady,
  output logic [DATA_W-1:0] cinData,
  output logic              cipherDecrypt,
  output logic              cipherChain,
  output logic              cipherFirst,
  input  logic              coutValid,
  output logic              coutReady,
  input  logic [DATA_W-1:0] coutData,
  output logic              irq
);
  seqStrobe_t        stb;
  logic              busy, wrStartReq, wrAbortReq, cipherEn, lastBlock;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [DATA_W-1:0] blockBuf;

  bcdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrStartReq(wrStartReq), .wrAbortReq(wrAbortReq),
    .cipherEn(cipherEn), .lastBlock(lastBlock),
    .memRdAck(memRdAck), .memRdErr(memRdErr),
    .memWrAck(memWrAck), .memWrErr(memWrErr),
    .cinReady(cinReady), .coutValid(coutValid),
    .stb(stb), .busy(busy),
    .memRdReq(memRdReq), .memWrReq(memWrReq),
    .cinValid(cinValid), .coutReady(coutReady)
  );

  bcdma_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .busy(busy), .stb(stb),
    .memRdData(memRdData), .coutData(coutData),
    .wrStartReq(wrStartReq), .wrAbortReq(wrAbortReq),
    .cipherEn(cipherEn), .decrypt(cipherDecrypt), .chainIv(cipherChain),
    .firstBlock(cipherFirst), .lastBlock(lastBlock),
    .srcAddr(srcAddr), .dstAddr(dstAddr),
    .blockBuf(blockBuf), .irq(irq)
  );

  assign memRdAddr = srcAddr;
  assign memWrAddr = dstAddr;
  assign memWrData = blockBuf;
  assign cinData   = blockBuf;
endmodule

// File: rtl/bcdma_checker.sv
`timescale 1ns/1ps
module bcdma_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [3:0]        regAddr,
  input logic              startBit,
  input logic              busy,
  input logic              cipherEn,
  input logic              memRdReq,
  input logic              memRdAck,
  input logic              memRdErr,
  input logic              memWrReq,
  input logic              memWrAck,
  input logic              memWrErr,
  input logic              cinValid,
  input logic              cinReady,
  input logic [DATA_W-1:0] cinData,
  input logic              coutReady,
  input logic [ADDR_W-1:0] srcAddr,
  input logic [ADDR_W-1:0] dstAddr,
  input logic              irq
);
  localparam int unsigned BlkBytes = DATA_W / 8;

  logic abortWr;
  assign abortWr = regWrEn && (regAddr == 4'h0) && !startBit;

  assert_single_req_R13: assert property (@(posedge clk) disable iff (!rstN)
    $countones({memRdReq, memWrReq, cinValid, coutReady}) <= 1);

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdAck && !abortWr |=> memRdReq);

  assert_wr_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && !memWrAck && !abortWr |=> memWrReq);

  assert_cin_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    cinValid && !cinReady && !abortWr |=> cinValid && $stable(cinData));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !cipherEn |-> !cinValid);

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && memWrAck && !memWrErr && !abortWr |=>
      (srcAddr == $past(srcAddr) + ADDR_W'(BlkBytes)) &&
      (dstAddr == $past(dstAddr) + ADDR_W'(BlkBytes)));

  assert_irq_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(busy));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    abortWr && busy |=> !busy && !memRdReq && !memWrReq);

  assert_err_stop_R12: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && memRdAck && memRdErr && !abortWr |=> !busy && $stable(srcAddr));
endmodule

bind blkcipher_dma_ctl bcdma_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .startBit(regWrData[31]), .busy(busy), .cipherEn(cipherEn),
  .memRdReq(memRdReq), .memRdAck(memRdAck), .memRdErr(memRdErr),
  .memWrReq(memWrReq), .memWrAck(memWrAck), .memWrErr(memWrErr),
  .cinValid(cinValid), .cinReady(cinReady), .cinData(cinData),
  .coutReady(coutReady), .srcAddr(srcAddr), .dstAddr(dstAddr), .irq(irq)
);

// File: tb/blkcipher_dma_ctl_tb_top.sv
`timescale 1ns/1ps
module blkcipher_dma_ctl_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         memRdReq, memWrReq, cinValid, coutReady, irq;
  logic [31:0]  memRdAddr, memWrAddr;
  logic [127:0] memWrData, cinData;
  logic         cipherDecrypt, cipherChain, cipherFirst;
  logic         memRdAck = 1'b0, memRdErr = 1'b0;
  logic [127:0] memRdData = '0;
  logic         memWrAck = 1'b0, memWrErr = 1'b0;
  logic         cinReady = 1'b0, coutValid = 1'b0;
  logic [127:0] coutData = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  bit stallRd = 0;
  logic [31:0] errAddr = 32'h1;

  logic [31:0]  logAddr [64];
  logic [127:0] logData [64];
  int           nWr = 0;
  logic         cinFirst [64];
  logic         cinDec   [64];
  logic         cinChain [64];
  int           nCin = 0;
  logic [127:0] capData;
  logic         capDec;
  bit           cinPend = 0;

  always #10 clk = ~clk;

  blkcipher_dma_ctl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdAck(memRdAck),
    .memRdErr(memRdErr), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrAck(memWrAck), .memWrErr(memWrErr),
    .cinValid(cinValid), .cinReady(cinReady), .cinData(cinData),
    .cipherDecrypt(cipherDecrypt), .cipherChain(cipherChain),
    .cipherFirst(cipherFirst), .coutValid(coutValid),
    .coutReady(coutReady), .coutData(coutData), .irq(irq)
  );

  function automatic logic [127:0] memPattern(input logic [31:0] a);
    return {a ^ 32'h1111_0000, ~a, a * 32'd3, a + 32'h55};
  endfunction

  function automatic logic [127:0] cipherModel(input logic [127:0] d, input logic dec);
    if (dec) return d ^ {4{32'h3C3C_C3C3}};
    return {d[63:0], d[127:64]} ^ {4{32'hA5A5_5A5A}};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory read responder
  initial begin
    forever begin
      @(negedge clk);
      if (memRdAck) begin
        memRdAck = 1'b0;
        memRdErr = 1'b0;
      end else if (memRdReq && !stallRd && ($urandom % 3 != 0)) begin
        memRdAck  = 1'b1;
        memRdData = memPattern(memRdAddr);
        memRdErr  = (memRdAddr == errAddr);
      end
    end
  end

  // memory write responder
  initial begin
    forever begin
      @(negedge clk);
      if (memWrAck) memWrAck = 1'b0;
      else if (memWrReq && ($urandom % 3 != 0)) begin
        memWrAck = 1'b1;
        logAddr[nWr % 64] = memWrAddr;
        logData[nWr % 64] = memWrData;
        nWr++;
      end
    end
  end

  // cipher responder
  initial begin
    forever begin
      @(negedge clk);
      if (cinReady) cinReady = 1'b0;
      else if (cinValid && !cinPend && ($urandom % 2 == 1)) begin
        cinReady = 1'b1;
        cinPend  = 1'b1;
        capData  = cinData;
        capDec   = cipherDecrypt;
        cinFirst[nCin % 64] = cipherFirst;
        cinDec[nCin % 64]   = cipherDecrypt;
        cinChain[nCin % 64] = cipherChain;
        nCin++;
      end
      if (coutValid) begin
        coutValid = 1'b0;
        cinPend   = 1'b0;
      end else if (cinPend && !cinReady && coutReady && ($urandom % 2 == 1)) begin
        coutValid = 1'b1;
        coutData  = cipherModel(capData, capDec);
      end
    end
  end

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      regRd(4'h0, v);
      if (!v[31]) return;
    end
  endtask

  task automatic clearLogs();
    nWr = 0;
    nCin = 0;
  endtask

  task automatic checkJob(input string tag, input logic [31:0] src, input logic [31:0] dst,
                          input int n, input logic ciph, input logic dec, input logic chain);
    logic [127:0] exp;
    chk({tag, " R4 block count"}, nWr, n);
    chk({tag, " R5 R6 cipher handshakes"}, nCin, ciph ? n : 0);
    for (int k = 0; k < n && k < 64; k++) begin
      exp = memPattern(src + 32'(16 * k));
      if (ciph) exp = cipherModel(exp, dec);
      chk({tag, " R4 write address"}, logAddr[k], dst + 32'(16 * k));
      chk({tag, ciph ? " R5 cipher data" : " R6 copy data"}, logData[k], exp);
      if (ciph) begin
        chk({tag, " R5 first flag"}, cinFirst[k], k == 0);
        chk({tag, " R5 decrypt flag"}, cinDec[k], dec);
        chk({tag, " R5 chain flag"}, cinChain[k], chain);
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, src, dst, r, ctl;
    int n;
    logic ciph, dec;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(4'h0, v); chk("R1 ctrl reset", v, 32'h0);
    regRd(4'h4, v); chk("R1 src reset", v, 32'h0);
    regRd(4'h8, v); chk("R1 dst reset", v, 32'h0);
    chk("R1 outputs idle", {memRdReq, memWrReq, cinValid, coutReady, irq}, 5'b0);

    // R7 R8 alignment of address registers
    regWr(4'h4, 32'h1000_000F); regRd(4'h4, v); chk("R7 R8 src low bits", v, 32'h1000_0000);
    regWr(4'h8, 32'h2000_0007); regRd(4'h8, v); chk("R7 R8 dst low bits", v, 32'h2000_0000);

    // R2 field layout, error bit not writable
    regWr(4'h0, 32'h5800_1005); regRd(4'h0, v); chk("R2 field readback", v, 32'h5800_1005);
    regWr(4'h0, 32'h2000_0000); regRd(4'h0, v); chk("R2 error not writable", v, 32'h0);

    // Job A: encrypt, 3 blocks, interrupt on
    clearLogs();
    regWr(4'h0, 32'hD000_0002);
    regRd(4'h0, v); chk("R3 busy after start", v[31], 1'b1);
    waitIdle();
    checkJob("jobA", 32'h1000_0000, 32'h2000_0000, 3, 1'b1, 1'b0, 1'b0);
    regRd(4'h4, v); chk("R7 src after 3 blocks", v, 32'h1000_0030);
    regRd(4'h8, v); chk("R7 dst after 3 blocks", v, 32'h2000_0030);
    chk("R9 irq raised", irq, 1'b1);
    repeat (4) @(negedge clk);
    chk("R9 irq held", irq, 1'b1);
    regWr(4'h0, 32'h0000_0000);
    chk("R9 irq cleared by ctrl write", irq, 1'b0);

    // Job B: bypass, count zero = one block, interrupt off
    regWr(4'h4, 32'h3000_0100); regWr(4'h8, 32'h3000_0800);
    clearLogs();
    regWr(4'h0, 32'h8000_0000);
    waitIdle();
    checkJob("jobB", 32'h3000_0100, 32'h3000_0800, 1, 1'b0, 1'b0, 1'b0);
    chk("R9 no irq when disabled", irq, 1'b0);

    // Job C: in-place decrypt with chaining, 2 blocks
    regWr(4'h4, 32'h4000_0040); regWr(4'h8, 32'h4000_0040);
    clearLogs();
    regWr(4'h0, 32'h9800_1001);
    waitIdle();
    checkJob("jobC", 32'h4000_0040, 32'h4000_0040, 2, 1'b1, 1'b1, 1'b1);
    regRd(4'h4, v); chk("R4 R7 in-place src end", v, 32'h4000_0060);
    regRd(4'h8, v); chk("R4 R7 in-place dst end", v, 32'h4000_0060);

    // Job D: writes while busy are ignored
    stallRd = 1;
    regWr(4'h4, 32'h5000_0000); regWr(4'h8, 32'h6000_0000);
    clearLogs();
    regWr(4'h0, 32'h8000_0003);
    repeat (2) @(negedge clk);
    regWr(4'h0, 32'hD800_1000);
    regRd(4'h0, v); chk("R10 start while busy ignored", v, 32'h8000_0003);
    regWr(4'h4, 32'h7000_0000);
    regRd(4'h4, v); chk("R8 src write while busy ignored", v, 32'h5000_0000);
    stallRd = 0;
    waitIdle();
    checkJob("jobD R10", 32'h5000_0000, 32'h6000_0000, 4, 1'b0, 1'b0, 1'b0);

    // Abort during a stalled read
    stallRd = 1;
    regWr(4'h4, 32'h0800_0000); regWr(4'h8, 32'h0900_0000);
    clearLogs();
    regWr(4'h0, 32'h9000_0004);
    repeat (3) @(negedge clk);
    regWr(4'h0, 32'h0000_0000);
    regRd(4'h0, v); chk("R11 busy dropped after abort", v, 32'h0);
    chk("R11 read request dropped", memRdReq, 1'b0);
    regRd(4'h4, v); chk("R11 src kept", v, 32'h0800_0000);
    stallRd = 0;
    repeat (10) @(negedge clk);
    chk("R11 no write after abort", nWr, 0);

    // Read error on the second block
    errAddr = 32'h0A00_0010;
    regWr(4'h4, 32'h0A00_0000); regWr(4'h8, 32'h0B00_0000);
    clearLogs();
    regWr(4'h0, 32'hC000_0002);
    waitIdle();
    chk("R12 one block before error", nWr, 1);
    regRd(4'h0, v); chk("R12 error flag set", v, 32'h6000_0002);
    regRd(4'h4, v); chk("R12 src not advanced by failing block", v, 32'h0A00_0010);
    regRd(4'h8, v); chk("R12 dst not advanced by failing block", v, 32'h0B00_0010);
    chk("R9 R12 irq on error end", irq, 1'b1);
    errAddr = 32'h1;
    clearLogs();
    regWr(4'h0, 32'h8000_0000);
    waitIdle();
    regRd(4'h0, v); chk("R12 error cleared by start", v, 32'h0);
    chk("R9 irq cleared by start write", irq, 1'b0);

    // Randomised jobs
    for (int j = 0; j < 8; j++) begin
      r = $urandom(); src = {r[31:4], 4'h0};
      r = $urandom(); dst = {r[31:4], 4'h0};
      n = int'($urandom % 6) + 1;
      ciph = 1'($urandom % 2);
      dec  = 1'($urandom % 2);
      ctl = 32'h8000_0000 | (32'(ciph) << 28) | (32'(dec) << 27) | 32'(n - 1);
      regWr(4'h4, src); regWr(4'h8, dst);
      clearLogs();
      regWr(4'h0, ctl);
      waitIdle();
      checkJob("random", src, dst, n, ciph, dec, 1'b0);
      regRd(4'h4, v); chk("R7 random src end", v, src + 32'(16 * n));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule